// File: doc/BRIEF.md
# Rank Power-Mode Controller

This block follows the power mode of one DRAM rank and issues the strobes that take the rank into and out of its low-power modes. The rank is in one of six modes: closed-idle, auto-refresh, self-refresh, power-down with all banks closed, active with at least one bank open, and power-down with banks open. The mode changes on a small set of inputs. These are bank-open status, a refresh start and done handshake from the refresh sequencer, a check pulse raised when a read response completes, and a wake request that comes from a drain or from a new access.

Self-refresh can only be reached through an auto-refresh that began in closed-bank power-down. When the auto-refresh ends, the mode that was held before it picks where the rank goes next, so a register saves that mode as the refresh begins. After any exit from a low-power mode, `ready_o` stays low for a parameterised number of cycles: `T_XP` after a power-down exit and `T_XS` after a self-refresh exit. A request that is not allowed in the current mode changes nothing and raises a one-cycle `illegal_o` pulse.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (closed-idle), `ready_o` is 1, and every strobe and `illegal_o` is 0.
- R2: `state_o` encodes the modes as 0 closed-idle, 1 auto-refresh, 2 self-refresh, 3 closed power-down, 4 active, 5 active power-down. In closed-idle, `any_bank_open_i`=1 moves the rank to active one cycle later. In active, `any_bank_open_i`=0 moves it back to closed-idle.
- R3: `ref_start_i` in closed-idle or closed power-down enters auto-refresh on the next cycle and saves the mode it left. In closed-idle it has priority over bank-open and power-down entry. In closed power-down it has priority over wake.
- R4: `ref_done_i` in auto-refresh ends it. If the saved mode was closed-idle, the rank returns to closed-idle. If the saved mode was closed power-down and both `pdn_en_i` and `queue_empty_i` are 1, the rank goes to self-refresh with a one-cycle `sref_enter_o`. Otherwise it returns to closed power-down with no strobe.
- R5: `rd_resp_done_i` with `pdn_en_i`, `queue_empty_i` and `ref_seq_idle_i` all 1 moves closed-idle to closed power-down and active to active power-down, each with a one-cycle `pdn_enter_o`. If any of the three enables is 0, the pulse has no effect.
- R6: `wake_i` moves closed power-down to closed-idle and active power-down to active, with a one-cycle `pdn_exit_o`. `ready_o` is low in the strobe cycle and for `T_XP`-1 further cycles, then rises.
- R7: `wake_i` in self-refresh moves the rank to closed-idle with a one-cycle `sref_exit_o`. `ready_o` is low in the strobe cycle and for `T_XS`-1 further cycles, then rises.
- R8: The allowed requests in each mode are:
  - closed-idle: `ref_start_i`
  - active: none
  - closed power-down: `ref_start_i`, `wake_i`
  - active power-down: `wake_i`
  - auto-refresh: `ref_done_i`
  - self-refresh: `wake_i`
  - while an exit count runs: none

  A cycle that carries any request not allowed in the current mode is ignored in full, and `illegal_o` is 1 in the next cycle. While an exit count runs, no mode change takes place.
- R9: `ready_o` is 1 only in closed-idle or active with no exit count running. It is 0 in every refresh and power-down mode.
- R10: The four command strobes each last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| any_bank_open_i | input | 1 | 1 when at least one bank of the rank is open |
| ref_start_i | input | 1 | Refresh sequencer asks to start auto-refresh |
| ref_done_i | input | 1 | Refresh sequencer reports auto-refresh complete |
| ref_seq_idle_i | input | 1 | Refresh sequencer is idle |
| rd_resp_done_i | input | 1 | A read response completed; triggers the power-down check |
| queue_empty_i | input | 1 | No requests queued for this rank |
| pdn_en_i | input | 1 | Power-down modes enabled |
| wake_i | input | 1 | Exit request from a drain or a new access |
| state_o | output | 3 | Current power mode, encoded as in R2 |
| pdn_enter_o | output | 1 | Power-down entry strobe |
| pdn_exit_o | output | 1 | Power-down exit strobe |
| sref_enter_o | output | 1 | Self-refresh entry strobe |
| sref_exit_o | output | 1 | Self-refresh exit strobe |
| ready_o | output | 1 | Rank usable for accesses |
| illegal_o | output | 1 | One-cycle pulse for a request that was ignored |

## Verification
The assertions assume that the request inputs are synchronous single-bit levels that are sampled each cycle. They do not assume that the inputs are mutually exclusive, because R8 says how conflicting or disallowed requests are handled. The stimulus draws every request line on its own with a low probability, and often sets several at once. It holds the enables high most of the time so that all six modes are visited and both exit windows are crossed. Directed sequences cover the self-refresh path, both power-down exits, and a check pulse that arrives while power-down is disabled.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;
  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_REF     = 3'd1,
    PS_SREF    = 3'd2,
    PS_PRE_PDN = 3'd3,
    PS_ACT     = 3'd4,
    PS_ACT_PDN = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/rank_pwr_legal.sv
module rank_pwr_legal
  import rank_pwr_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       exit_busy_i,
  input  logic       ref_start_i,
  input  logic       ref_done_i,
  input  logic       wake_i,
  output logic       illegal_o
);
  always_comb begin
    if (exit_busy_i) begin
      illegal_o = ref_start_i | ref_done_i | wake_i;
    end else begin
      unique case (state_i)
        PS_IDLE:    illegal_o = ref_done_i | wake_i;
        PS_ACT:     illegal_o = ref_start_i | ref_done_i | wake_i;
        PS_PRE_PDN: illegal_o = ref_done_i;
        PS_ACT_PDN: illegal_o = ref_start_i | ref_done_i;
        PS_REF:     illegal_o = ref_start_i | wake_i;
        PS_SREF:    illegal_o = ref_start_i | ref_done_i;
        default:    illegal_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rank_pwr_next.sv
module rank_pwr_next
  import rank_pwr_pkg::*;
(
  input  pwr_state_e state_i,
  input  pwr_state_e prior_i,
  input  logic       hold_i,
  input  logic       any_bank_open_i,
  input  logic       ref_start_i,
  input  logic       ref_done_i,
  input  logic       wake_i,
  input  logic       pdn_ok_i,
  input  logic       pdn_en_i,
  input  logic       queue_empty_i,
  output pwr_state_e state_o,
  output logic       save_prior_o,
  output logic       pdn_enter_o,
  output logic       pdn_exit_o,
  output logic       sref_enter_o,
  output logic       sref_exit_o,
  output logic       exit_load_o,
  output logic       exit_long_o
);
  always_comb begin
    state_o      = state_i;
    save_prior_o = 1'b0;
    pdn_enter_o  = 1'b0;
    pdn_exit_o   = 1'b0;
    sref_enter_o = 1'b0;
    sref_exit_o  = 1'b0;
    exit_load_o  = 1'b0;
    exit_long_o  = 1'b0;
    if (!hold_i) begin
      unique case (state_i)
        PS_IDLE: begin
          if (ref_start_i) begin
            state_o      = PS_REF;
            save_prior_o = 1'b1;
          end else if (any_bank_open_i) begin
            state_o = PS_ACT;
          end else if (pdn_ok_i) begin
            state_o     = PS_PRE_PDN;
            pdn_enter_o = 1'b1;
          end
        end
        PS_ACT: begin
          if (!any_bank_open_i) begin
            state_o = PS_IDLE;
          end else if (pdn_ok_i) begin
            state_o     = PS_ACT_PDN;
            pdn_enter_o = 1'b1;
          end
        end
        PS_PRE_PDN: begin
          if (ref_start_i) begin
            state_o      = PS_REF;
            save_prior_o = 1'b1;
          end else if (wake_i) begin
            state_o     = PS_IDLE;
            pdn_exit_o  = 1'b1;
            exit_load_o = 1'b1;
          end
        end
        PS_ACT_PDN: begin
          if (wake_i) begin
            state_o     = PS_ACT;
            pdn_exit_o  = 1'b1;
            exit_load_o = 1'b1;
          end
        end
        PS_REF: begin
          if (ref_done_i) begin
            if (prior_i == PS_PRE_PDN) begin
              if (pdn_en_i && queue_empty_i) begin
                state_o      = PS_SREF;
                sref_enter_o = 1'b1;
              end else begin
                state_o = PS_PRE_PDN;
              end
            end else begin
              state_o = PS_IDLE;
            end
          end
        end
        PS_SREF: begin
          if (wake_i) begin
            state_o     = PS_IDLE;
            sref_exit_o = 1'b1;
            exit_load_o = 1'b1;
            exit_long_o = 1'b1;
          end
        end
        default: state_o = PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rank_pwr_exit_timer.sv
module rank_pwr_exit_timer #(
  parameter int unsigned T_XP = 5,
  parameter int unsigned T_XS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int unsigned MaxT = (T_XS > T_XP) ? T_XS : T_XP;
  localparam int unsigned CntW = $clog2(MaxT + 1);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= long_i ? CntW'(T_XS) : CntW'(T_XP);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int unsigned T_XP = 5,
  parameter int unsigned T_XS = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_bank_open_i,
  input  logic       ref_start_i,
  input  logic       ref_done_i,
  input  logic       ref_seq_idle_i,
  input  logic       rd_resp_done_i,
  input  logic       queue_empty_i,
  input  logic       pdn_en_i,
  input  logic       wake_i,
  output logic [2:0] state_o,
  output logic       pdn_enter_o,
  output logic       pdn_exit_o,
  output logic       sref_enter_o,
  output logic       sref_exit_o,
  output logic       ready_o,
  output logic       illegal_o
);
  pwr_state_e state_q, state_d, prior_q;
  logic       exit_busy, illegal_d, save_prior, exit_load, exit_long, pdn_ok;
  logic [3:0] strb_d, strb_q;

  assign pdn_ok = rd_resp_done_i & pdn_en_i & queue_empty_i & ref_seq_idle_i;

  rank_pwr_legal u_legal (
    .state_i     (state_q),
    .exit_busy_i (exit_busy),
    .ref_start_i (ref_start_i),
    .ref_done_i  (ref_done_i),
    .wake_i      (wake_i),
    .illegal_o   (illegal_d)
  );

  rank_pwr_next u_next (
    .state_i         (state_q),
    .prior_i         (prior_q),
    .hold_i          (exit_busy | illegal_d),
    .any_bank_open_i (any_bank_open_i),
    .ref_start_i     (ref_start_i),
    .ref_done_i      (ref_done_i),
    .wake_i          (wake_i),
    .pdn_ok_i        (pdn_ok),
    .pdn_en_i        (pdn_en_i),
    .queue_empty_i   (queue_empty_i),
    .state_o         (state_d),
    .save_prior_o    (save_prior),
    .pdn_enter_o     (strb_d[0]),
    .pdn_exit_o      (strb_d[1]),
    .sref_enter_o    (strb_d[2]),
    .sref_exit_o     (strb_d[3]),
    .exit_load_o     (exit_load),
    .exit_long_o     (exit_long)
  );

  rank_pwr_exit_timer #(.T_XP(T_XP), .T_XS(T_XS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (exit_load),
    .long_i (exit_long),
    .busy_o (exit_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_IDLE;
      prior_q   <= PS_IDLE;
      strb_q    <= '0;
      illegal_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      strb_q    <= strb_d;
      illegal_o <= illegal_d;
      if (save_prior) prior_q <= state_q;
    end
  end

  assign state_o      = state_q;
  assign pdn_enter_o  = strb_q[0];
  assign pdn_exit_o   = strb_q[1];
  assign sref_enter_o = strb_q[2];
  assign sref_exit_o  = strb_q[3];
  assign ready_o      = !exit_busy && (state_q == PS_IDLE || state_q == PS_ACT);
endmodule

// File: rtl/rank_pwr_ctrl_chk.sv
module rank_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_o,
  input logic       pdn_enter_o,
  input logic       pdn_exit_o,
  input logic       sref_enter_o,
  input logic       sref_exit_o,
  input logic       ready_o,
  input logic       illegal_o
);
  AST_SREF_ONLY_FROM_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && !$stable(state_o)) |-> $past(state_o) == 3'd1); // R4
  AST_ACT_PDN_TO_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> state_o == 3'd4); // R6
  AST_SREF_EXIT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sref_exit_o |-> !ready_o); // R7
  AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(state_o)); // R8
  AST_LOW_POWER_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o inside {3'd1, 3'd2, 3'd3, 3'd5}) |-> !ready_o); // R9
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pdn_enter_o, pdn_exit_o, sref_enter_o, sref_exit_o}) <= 1); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_enter_o || sref_enter_o) |=> !(pdn_enter_o || sref_enter_o)); // R10
endmodule

bind rank_pwr_ctrl rank_pwr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_o      (state_o),
  .pdn_enter_o  (pdn_enter_o),
  .pdn_exit_o   (pdn_exit_o),
  .sref_enter_o (sref_enter_o),
  .sref_exit_o  (sref_exit_o),
  .ready_o      (ready_o),
  .illegal_o    (illegal_o)
);

// File: tb/tb_rank_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_rank_pwr_ctrl;
  localparam int TXP = 5;
  localparam int TXS = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bo = 0, rs = 0, rdn = 0, si = 1, rr = 0, qe = 1, pe = 1, wk = 0;
  logic [2:0] st;
  logic pen, pex, sen, sex, rdy, ill;

  int checks = 0, fails = 0;
  int m_state = 0, m_prior = 0, m_cnt = 0;
  logic m_pen = 0, m_pex = 0, m_sen = 0, m_sex = 0, m_ill = 0;

  always #4 clk = ~clk;

  rank_pwr_ctrl #(.T_XP(TXP), .T_XS(TXS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .any_bank_open_i(bo), .ref_start_i(rs),
    .ref_done_i(rdn), .ref_seq_idle_i(si), .rd_resp_done_i(rr),
    .queue_empty_i(qe), .pdn_en_i(pe), .wake_i(wk), .state_o(st),
    .pdn_enter_o(pen), .pdn_exit_o(pex), .sref_enter_o(sen),
    .sref_exit_o(sex), .ready_o(rdy), .illegal_o(ill)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_ready();
    return (m_cnt == 0) && (m_state == 0 || m_state == 4);
  endfunction

  // expected next mode per R2..R8
  task automatic model_step();
    logic illx, pok;
    m_pen = 0; m_pex = 0; m_sen = 0; m_sex = 0;
    pok = rr & pe & qe & si;
    if (m_cnt != 0) illx = rs | rdn | wk;
    else case (m_state)
      0: illx = rdn | wk;
      4: illx = rs | rdn | wk;
      3: illx = rdn;
      5: illx = rs | rdn;
      1: illx = rs | wk;
      default: illx = rs | rdn;
    endcase
    m_ill = illx;
    if (m_cnt != 0) m_cnt--;
    else if (!illx) case (m_state)
      0: if (rs) begin m_prior = 0; m_state = 1; end
         else if (bo) m_state = 4;
         else if (pok) begin m_state = 3; m_pen = 1; end
      4: if (!bo) m_state = 0;
         else if (pok) begin m_state = 5; m_pen = 1; end
      3: if (rs) begin m_prior = 3; m_state = 1; end
         else if (wk) begin m_state = 0; m_pex = 1; m_cnt = TXP; end
      5: if (wk) begin m_state = 4; m_pex = 1; m_cnt = TXP; end
      1: if (rdn) begin
           if (m_prior == 3) begin
             if (pe && qe) begin m_state = 2; m_sen = 1; end
             else m_state = 3;
           end else m_state = 0;
         end
      default: if (wk) begin m_state = 0; m_sex = 1; m_cnt = TXS; end
    endcase
  endtask

  task automatic compare_all();
    chk(st == m_state, "R2 state", st, m_state);
    chk(rdy == m_ready(), "R9 ready", rdy, m_ready());
    chk(pen == m_pen, "R5 pdn_enter", pen, m_pen);
    chk(pex == m_pex, "R6 pdn_exit", pex, m_pex);
    chk(sen == m_sen, "R4 sref_enter", sen, m_sen);
    chk(sex == m_sex, "R7 sref_exit", sex, m_sex);
    chk(ill == m_ill, "R8 illegal", ill, m_ill);
    chk($countones({pen, pex, sen, sex}) <= 1, "R10 strobes", $countones({pen, pex, sen, sex}), 1);
  endtask

  // inputs set at negedge, model advanced for the coming posedge
  task automatic cyc();
    model_step();
    @(negedge clk);
    compare_all();
    rs = 0; rdn = 0; rr = 0; wk = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(st == 0 && rdy == 1 && {pen, pex, sen, sex, ill} == 0, "R1 reset", st, 0);
    rst_n = 1;
    @(negedge clk);
    chk(st == 0 && rdy == 1, "R1 after release", st, 0);

    rr = 1; cyc();
    chk(st == 3 && pen == 1, "R5 idle to closed pdn", st, 3);
    rs = 1; cyc();
    chk(st == 1 && rdy == 0, "R3 refresh from pdn", st, 1);
    rdn = 1; cyc();
    chk(st == 2 && sen == 1, "R4 refresh to sref", st, 2);
    rs = 1; cyc();
    chk(st == 2 && ill == 1, "R8 ignored in sref", st, 2);
    wk = 1; cyc();
    chk(st == 0 && sex == 1 && rdy == 0, "R7 sref exit", st, 0);
    for (int i = 1; i < TXS; i++) begin
      cyc();
      chk(rdy == 0, "R7 ready held low", rdy, 0);
    end
    cyc();
    chk(rdy == 1, "R7 ready after T_XS", rdy, 1);

    bo = 1; cyc();
    chk(st == 4, "R2 idle to active", st, 4);
    rr = 1; cyc();
    chk(st == 5 && pen == 1, "R5 active pdn", st, 5);
    rs = 1; cyc();
    chk(st == 5 && ill == 1, "R8 refresh in active pdn", st, 5);
    wk = 1; cyc();
    chk(st == 4 && pex == 1 && rdy == 0, "R6 pdn exit", st, 4);
    for (int i = 1; i < TXP; i++) cyc();
    chk(rdy == 0, "R6 ready low last cycle", rdy, 0);
    cyc();
    chk(rdy == 1, "R6 ready after T_XP", rdy, 1);

    bo = 0; cyc();
    chk(st == 0, "R2 active to idle", st, 0);
    rs = 1; cyc();
    chk(st == 1, "R3 refresh from idle", st, 1);
    rdn = 1; cyc();
    chk(st == 0 && sen == 0, "R4 refresh back to idle", st, 0);
    pe = 0; rr = 1; cyc();
    chk(st == 0 && pen == 0, "R5 disabled no effect", st, 0);
    pe = 1;

    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(15) == 0) bo = ~bo;
      rs  = ($urandom_range(9) == 0);
      rdn = ($urandom_range(7) == 0);
      wk  = ($urandom_range(7) == 0);
      rr  = ($urandom_range(3) == 0);
      pe  = ($urandom_range(9) != 0);
      qe  = ($urandom_range(7) != 0);
      si  = ($urandom_range(7) != 0);
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule